// File: doc/BRIEF.md
# Instruction Cache Line Poisoning Controller

This block sits beside an instruction cache. It holds the enable bit for the cache's ECC checking and runs a short sequence that deliberately corrupts one cache line, so that software can exercise its error handling. Software reaches two 64-bit registers through a simple register read/write port that decodes a 128-byte window. One register holds the control fields. The other holds the physical address of the line to corrupt.

When software sets the start bit, the block first validates the request. It then reads the tag array at the set selected by the programmed address and compares the address tag against every valid way. On a hit, it rewrites either the tag array or the data array at the matching way with the poison flag raised. A status field reports the outcome, and a reason field explains a failure. While the sequence runs, the block takes the tag-read, tag-write, data-read and data-write ports away from the normal cache pipelines. When it is idle, it hands them back unchanged.

Top module: `icache_poison_ctl`

## Requirements
- R1: After reset, both registers read 0, `ecc_check_en` is 0, and every array port carries the pipeline's signals.
- R2: A register access is decoded only when `reg_addr` falls in the 128-byte window at `BASE_ADDR`. Word 0 is control: bit 0 is the check enable, bit 1 is start (always reads 0), bits 3:2 are the target, bits 6:4 are the status and bits 9:7 are the reason. Status and reason ignore writes, and bits 63:10 read 0. Word 1 (offset 0x08) keeps bits `PADDR_W-1:0`. Any other word reads 0. `ecc_check_en` follows control bit 0.
- R3: Writing start with the enable bit 0 in the same write sets status 7 and reason 0, and starts no array access. This check takes priority over the target check.
- R4: Writing start with enable 1 and target 1 or 3 sets status 7 and reason 1, and starts no array access.
- R5: A valid start (target 0 = tag array, 2 = data array) sets status 1 in the next cycle. It raises `arr_mrd_valid` with set = paddr[`SET_LO`+:`SET_W`] and holds it until `arr_mrd_ready`, then drops it.
- R6: After the read handshake, the block waits for `arr_mrsp_valid`. If no way has both its valid bit set and a stored tag equal to paddr[`PADDR_W-1`:`TAG_LO`], it sets status 7 and reason 2, returns to idle, and issues no write.
- R7: On a hit with target 0, the block issues a tag write with `arr_mwr_poison`=1. The write carries the addressed set, a one-hot way that is the lowest hitting way, and the address tag, and is held until `arr_mwr_ready`. Status then reads 2.
- R8: On a hit with target 2, the block issues a data write with `arr_dwr_poison`=1 to the same set and lowest hitting way, held until `arr_dwr_ready`. Status then reads 2.
- R9: While the sequence is busy, every pipeline ready is 0 and the array ports carry the block's own requests. While idle, every array port output equals the pipeline input, every pipeline ready equals the array ready, and poison is 0.
- R10: Writes to either register while the sequence is busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_re` |
| ecc_check_en | output | 1 | ECC check enable to the main pipeline |
| pl_mrd_valid | input | 1 | Pipeline tag read request |
| pl_mrd_set | input | SET_W | Pipeline tag read set |
| pl_mrd_ready | output | 1 | Tag read accepted for pipeline |
| pl_mwr_valid | input | 1 | Pipeline tag write request |
| pl_mwr_set | input | SET_W | Pipeline tag write set |
| pl_mwr_way | input | WAYS | Pipeline tag write way, one-hot |
| pl_mwr_tag | input | TAG_W | Pipeline tag write value |
| pl_mwr_ready | output | 1 | Tag write accepted for pipeline |
| pl_drd_valid | input | 1 | Pipeline data read request |
| pl_drd_set | input | SET_W | Pipeline data read set |
| pl_drd_ready | output | 1 | Data read accepted for pipeline |
| pl_dwr_valid | input | 1 | Pipeline data write request |
| pl_dwr_set | input | SET_W | Pipeline data write set |
| pl_dwr_way | input | WAYS | Pipeline data write way, one-hot |
| pl_dwr_data | input | LINE_W | Pipeline data write value |
| pl_dwr_ready | output | 1 | Data write accepted for pipeline |
| arr_mrd_valid | output | 1 | Tag array read request |
| arr_mrd_set | output | SET_W | Tag array read set |
| arr_mrd_ready | input | 1 | Tag array read accept |
| arr_mrsp_valid | input | 1 | Tag array read response valid |
| arr_mrsp_tags | input | WAYS*TAG_W | Stored tags, way w at bits w*TAG_W |
| arr_mrsp_vbits | input | WAYS | Line valid bit per way |
| arr_mwr_valid | output | 1 | Tag array write request |
| arr_mwr_set | output | SET_W | Tag array write set |
| arr_mwr_way | output | WAYS | Tag array write way, one-hot |
| arr_mwr_tag | output | TAG_W | Tag array write value |
| arr_mwr_poison | output | 1 | Mark written tag entry as corrupt |
| arr_mwr_ready | input | 1 | Tag array write accept |
| arr_drd_valid | output | 1 | Data array read request |
| arr_drd_set | output | SET_W | Data array read set |
| arr_drd_ready | input | 1 | Data array read accept |
| arr_dwr_valid | output | 1 | Data array write request |
| arr_dwr_set | output | SET_W | Data array write set |
| arr_dwr_way | output | WAYS | Data array write way, one-hot |
| arr_dwr_data | output | LINE_W | Data array write value |
| arr_dwr_poison | output | 1 | Mark written data entry as corrupt |
| arr_dwr_ready | input | 1 | Data array write accept |

## Verification
A sequencer stuck in, or skipping, a state shows at the array ports within one cycle. A read request would fail to drop after its handshake, a write would appear after a miss, or a pipeline ready would stay low after the sequence ends. A wrong status or reason register shows on the next control read. The bench therefore reads the control word after every step that should change it. A mis-selected way or set shows in the payload of the poisoned write in the cycle that write is offered.

// File: rtl/poison_pkg.sv
package poison_pkg;
  localparam int REG_W = 64;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD_REQ,
    SEQ_RD_RSP,
    SEQ_WR_TAG,
    SEQ_WR_DATA
  } seq_st_e;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_WORK = 3'd1;
  localparam logic [2:0] ST_DONE = 3'd2;
  localparam logic [2:0] ST_FAIL = 3'd7;

  localparam logic [2:0] RSN_OFF  = 3'd0;
  localparam logic [2:0] RSN_TGT  = 3'd1;
  localparam logic [2:0] RSN_MISS = 3'd2;

  localparam logic [1:0] TGT_TAG  = 2'd0;
  localparam logic [1:0] TGT_DATA = 2'd2;
endpackage

// File: rtl/poison_regs.sv
module poison_regs
  import poison_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h3802_2080,
  parameter int PADDR_W = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               busy_i,
  input  logic               seq_ok_i,
  input  logic               seq_miss_i,
  output logic               start_o,
  output logic               en_o,
  output logic [1:0]         tgt_o,
  output logic [PADDR_W-1:0] paddr_o
);
  localparam int WIN_LSB = 7;   // 128-byte window
  localparam int WORD_LSB = 3;  // 8-byte words

  logic               en_q;
  logic [1:0]         tgt_q;
  logic [2:0]         stat_q, rsn_q;
  logic [PADDR_W-1:0] paddr_q;

  logic in_win, wr_ctrl, wr_addr, tgt_ok;
  logic [WIN_LSB-WORD_LSB-1:0] word;
  logic unused_bits;

  assign in_win  = reg_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB];
  assign word    = reg_addr[WIN_LSB-1:WORD_LSB];
  assign wr_ctrl = reg_we && in_win && (word == 4'd0) && !busy_i;
  assign wr_addr = reg_we && in_win && (word == 4'd1) && !busy_i;
  assign tgt_ok  = (reg_wdata[3:2] == TGT_TAG) || (reg_wdata[3:2] == TGT_DATA);
  assign start_o = wr_ctrl && reg_wdata[1] && reg_wdata[0] && tgt_ok;
  assign unused_bits = ^{reg_wdata[REG_W-1:PADDR_W], reg_addr[WORD_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      tgt_q   <= 2'd0;
      stat_q  <= ST_IDLE;
      rsn_q   <= RSN_OFF;
      paddr_q <= '0;
    end else begin
      if (seq_ok_i) stat_q <= ST_DONE;
      if (seq_miss_i) begin
        stat_q <= ST_FAIL;
        rsn_q  <= RSN_MISS;
      end
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        tgt_q <= reg_wdata[3:2];
        if (reg_wdata[1]) begin
          if (!reg_wdata[0]) begin
            stat_q <= ST_FAIL;
            rsn_q  <= RSN_OFF;
          end else if (!tgt_ok) begin
            stat_q <= ST_FAIL;
            rsn_q  <= RSN_TGT;
          end else begin
            stat_q <= ST_WORK;
            rsn_q  <= RSN_OFF;
          end
        end
      end
      if (wr_addr) paddr_q <= reg_wdata[PADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      reg_rdata <= '0;
      if (in_win && word == 4'd0)
        reg_rdata <= {{(REG_W-10){1'b0}}, rsn_q, stat_q, tgt_q, 1'b0, en_q};
      else if (in_win && word == 4'd1)
        reg_rdata <= {{(REG_W-PADDR_W){1'b0}}, paddr_q};
    end
  end

  assign en_o    = en_q;
  assign tgt_o   = tgt_q;
  assign paddr_o = paddr_q;

  // R5
  start_sets_work_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (stat_q == ST_WORK));
  // R2
  stat_code_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_IDLE) || (stat_q == ST_WORK) || (stat_q == ST_DONE) || (stat_q == ST_FAIL));
  // R10
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i && !seq_ok_i && !seq_miss_i |=> $stable(paddr_q) && $stable(tgt_q));
endmodule

// File: rtl/poison_seq.sv
module poison_seq
  import poison_pkg::*;
#(
  parameter int PADDR_W = 36,
  parameter int SET_LO  = 6,
  parameter int SET_W   = 6,
  parameter int TAG_LO  = 12,
  parameter int WAYS    = 4,
  parameter int LINE_W  = 64,
  localparam int TAG_W  = PADDR_W - TAG_LO
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [1:0]            tgt_i,
  input  logic [PADDR_W-1:0]    paddr_i,
  output logic                  busy_o,
  output logic                  ok_o,
  output logic                  miss_o,
  output logic                  rd_valid_o,
  output logic [SET_W-1:0]      set_o,
  input  logic                  rd_ready_i,
  input  logic                  rsp_valid_i,
  input  logic [WAYS*TAG_W-1:0] rsp_tags_i,
  input  logic [WAYS-1:0]       rsp_vbits_i,
  output logic                  mwr_valid_o,
  output logic [WAYS-1:0]       way_o,
  output logic [TAG_W-1:0]      tag_o,
  input  logic                  mwr_ready_i,
  output logic                  dwr_valid_o,
  output logic [LINE_W-1:0]     data_o,
  input  logic                  dwr_ready_i
);
  seq_st_e st_q;
  logic [WAYS-1:0] hit_vec, hit_pick, hit_q;
  logic [TAG_W-1:0] ptag;
  logic unused_low;

  assign ptag  = paddr_i[PADDR_W-1:TAG_LO];
  assign set_o = paddr_i[SET_LO +: SET_W];
  assign unused_low = ^paddr_i[SET_LO-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rsp_vbits_i[w] && (rsp_tags_i[w*TAG_W +: TAG_W] == ptag);
  end

  always_comb begin
    hit_pick = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_pick = WAYS'(1) << w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      hit_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE:    if (start_i) st_q <= SEQ_RD_REQ;
        SEQ_RD_REQ:  if (rd_ready_i) st_q <= SEQ_RD_RSP;
        SEQ_RD_RSP:
          if (rsp_valid_i) begin
            if (|hit_vec) begin
              hit_q <= hit_pick;
              st_q  <= (tgt_i == TGT_DATA) ? SEQ_WR_DATA : SEQ_WR_TAG;
            end else begin
              st_q <= SEQ_IDLE;
            end
          end
        SEQ_WR_TAG:  if (mwr_ready_i) st_q <= SEQ_IDLE;
        SEQ_WR_DATA: if (dwr_ready_i) st_q <= SEQ_IDLE;
        default:     st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = st_q != SEQ_IDLE;
  assign rd_valid_o  = st_q == SEQ_RD_REQ;
  assign mwr_valid_o = st_q == SEQ_WR_TAG;
  assign dwr_valid_o = st_q == SEQ_WR_DATA;
  assign way_o       = hit_q;
  assign tag_o       = ptag;
  assign data_o      = '0;
  assign ok_o   = (mwr_valid_o && mwr_ready_i) || (dwr_valid_o && dwr_ready_i);
  assign miss_o = (st_q == SEQ_RD_RSP) && rsp_valid_i && !(|hit_vec);

  // R5
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(set_o));
  // R7
  tag_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mwr_valid_o && !mwr_ready_i |=> mwr_valid_o && $stable(way_o));
  // R8
  data_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dwr_valid_o && !dwr_ready_i |=> dwr_valid_o && $stable(way_o));
  // R7
  way_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (mwr_valid_o || dwr_valid_o) |-> $onehot0(way_o) && (way_o != '0));
  // R6
  miss_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    miss_o |=> !busy_o);
endmodule

// File: rtl/poison_port_mux.sv
module poison_port_mux #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 24,
  parameter int WAYS   = 4,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              u_mrd_valid,
  input  logic [SET_W-1:0]  u_set,
  input  logic              u_mwr_valid,
  input  logic [WAYS-1:0]   u_way,
  input  logic [TAG_W-1:0]  u_tag,
  input  logic              u_dwr_valid,
  input  logic [LINE_W-1:0] u_data,
  input  logic              pl_mrd_valid,
  input  logic [SET_W-1:0]  pl_mrd_set,
  output logic              pl_mrd_ready,
  input  logic              pl_mwr_valid,
  input  logic [SET_W-1:0]  pl_mwr_set,
  input  logic [WAYS-1:0]   pl_mwr_way,
  input  logic [TAG_W-1:0]  pl_mwr_tag,
  output logic              pl_mwr_ready,
  input  logic              pl_drd_valid,
  input  logic [SET_W-1:0]  pl_drd_set,
  output logic              pl_drd_ready,
  input  logic              pl_dwr_valid,
  input  logic [SET_W-1:0]  pl_dwr_set,
  input  logic [WAYS-1:0]   pl_dwr_way,
  input  logic [LINE_W-1:0] pl_dwr_data,
  output logic              pl_dwr_ready,
  output logic              arr_mrd_valid,
  output logic [SET_W-1:0]  arr_mrd_set,
  input  logic              arr_mrd_ready,
  output logic              arr_mwr_valid,
  output logic [SET_W-1:0]  arr_mwr_set,
  output logic [WAYS-1:0]   arr_mwr_way,
  output logic [TAG_W-1:0]  arr_mwr_tag,
  output logic              arr_mwr_poison,
  input  logic              arr_mwr_ready,
  output logic              arr_drd_valid,
  output logic [SET_W-1:0]  arr_drd_set,
  input  logic              arr_drd_ready,
  output logic              arr_dwr_valid,
  output logic [SET_W-1:0]  arr_dwr_set,
  output logic [WAYS-1:0]   arr_dwr_way,
  output logic [LINE_W-1:0] arr_dwr_data,
  output logic              arr_dwr_poison,
  input  logic              arr_dwr_ready
);
  always_comb begin
    if (busy_i) begin
      arr_mrd_valid  = u_mrd_valid;
      arr_mrd_set    = u_set;
      arr_mwr_valid  = u_mwr_valid;
      arr_mwr_set    = u_set;
      arr_mwr_way    = u_way;
      arr_mwr_tag    = u_tag;
      arr_mwr_poison = u_mwr_valid;
      arr_drd_valid  = 1'b0;
      arr_drd_set    = u_set;
      arr_dwr_valid  = u_dwr_valid;
      arr_dwr_set    = u_set;
      arr_dwr_way    = u_way;
      arr_dwr_data   = u_data;
      arr_dwr_poison = u_dwr_valid;
    end else begin
      arr_mrd_valid  = pl_mrd_valid;
      arr_mrd_set    = pl_mrd_set;
      arr_mwr_valid  = pl_mwr_valid;
      arr_mwr_set    = pl_mwr_set;
      arr_mwr_way    = pl_mwr_way;
      arr_mwr_tag    = pl_mwr_tag;
      arr_mwr_poison = 1'b0;
      arr_drd_valid  = pl_drd_valid;
      arr_drd_set    = pl_drd_set;
      arr_dwr_valid  = pl_dwr_valid;
      arr_dwr_set    = pl_dwr_set;
      arr_dwr_way    = pl_dwr_way;
      arr_dwr_data   = pl_dwr_data;
      arr_dwr_poison = 1'b0;
    end
  end

  assign pl_mrd_ready = !busy_i && arr_mrd_ready;
  assign pl_mwr_ready = !busy_i && arr_mwr_ready;
  assign pl_drd_ready = !busy_i && arr_drd_ready;
  assign pl_dwr_ready = !busy_i && arr_dwr_ready;

  // R9
  pipe_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !(pl_mrd_ready || pl_mwr_ready || pl_drd_ready || pl_dwr_ready));
  // R9
  no_idle_poison_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_i |-> !arr_mwr_poison && !arr_dwr_poison);
endmodule

// File: rtl/icache_poison_ctl.sv
module icache_poison_ctl
  import poison_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h3802_2080,
  parameter int PADDR_W = 36,
  parameter int SET_LO  = 6,
  parameter int SET_W   = 6,
  parameter int TAG_LO  = 12,
  parameter int WAYS    = 4,
  parameter int LINE_W  = 64,
  localparam int TAG_W  = PADDR_W - TAG_LO
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           reg_rdata,
  output logic                  ecc_check_en,
  input  logic                  pl_mrd_valid,
  input  logic [SET_W-1:0]      pl_mrd_set,
  output logic                  pl_mrd_ready,
  input  logic                  pl_mwr_valid,
  input  logic [SET_W-1:0]      pl_mwr_set,
  input  logic [WAYS-1:0]       pl_mwr_way,
  input  logic [TAG_W-1:0]      pl_mwr_tag,
  output logic                  pl_mwr_ready,
  input  logic                  pl_drd_valid,
  input  logic [SET_W-1:0]      pl_drd_set,
  output logic                  pl_drd_ready,
  input  logic                  pl_dwr_valid,
  input  logic [SET_W-1:0]      pl_dwr_set,
  input  logic [WAYS-1:0]       pl_dwr_way,
  input  logic [LINE_W-1:0]     pl_dwr_data,
  output logic                  pl_dwr_ready,
  output logic                  arr_mrd_valid,
  output logic [SET_W-1:0]      arr_mrd_set,
  input  logic                  arr_mrd_ready,
  input  logic                  arr_mrsp_valid,
  input  logic [WAYS*TAG_W-1:0] arr_mrsp_tags,
  input  logic [WAYS-1:0]       arr_mrsp_vbits,
  output logic                  arr_mwr_valid,
  output logic [SET_W-1:0]      arr_mwr_set,
  output logic [WAYS-1:0]       arr_mwr_way,
  output logic [TAG_W-1:0]      arr_mwr_tag,
  output logic                  arr_mwr_poison,
  input  logic                  arr_mwr_ready,
  output logic                  arr_drd_valid,
  output logic [SET_W-1:0]      arr_drd_set,
  input  logic                  arr_drd_ready,
  output logic                  arr_dwr_valid,
  output logic [SET_W-1:0]      arr_dwr_set,
  output logic [WAYS-1:0]       arr_dwr_way,
  output logic [LINE_W-1:0]     arr_dwr_data,
  output logic                  arr_dwr_poison,
  input  logic                  arr_dwr_ready
);
  logic               busy, seq_ok, seq_miss, start;
  logic [1:0]         tgt;
  logic [PADDR_W-1:0] paddr;
  logic               u_mrd_valid, u_mwr_valid, u_dwr_valid;
  logic [SET_W-1:0]   u_set;
  logic [WAYS-1:0]    u_way;
  logic [TAG_W-1:0]   u_tag;
  logic [LINE_W-1:0]  u_data;

  poison_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .PADDR_W(PADDR_W)) u_regs (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .busy_i(busy), .seq_ok_i(seq_ok), .seq_miss_i(seq_miss),
    .start_o(start), .en_o(ecc_check_en), .tgt_o(tgt), .paddr_o(paddr)
  );

  poison_seq #(.PADDR_W(PADDR_W), .SET_LO(SET_LO), .SET_W(SET_W), .TAG_LO(TAG_LO),
               .WAYS(WAYS), .LINE_W(LINE_W)) u_seq (
    .clk, .rst, .start_i(start), .tgt_i(tgt), .paddr_i(paddr),
    .busy_o(busy), .ok_o(seq_ok), .miss_o(seq_miss),
    .rd_valid_o(u_mrd_valid), .set_o(u_set), .rd_ready_i(arr_mrd_ready),
    .rsp_valid_i(arr_mrsp_valid), .rsp_tags_i(arr_mrsp_tags), .rsp_vbits_i(arr_mrsp_vbits),
    .mwr_valid_o(u_mwr_valid), .way_o(u_way), .tag_o(u_tag), .mwr_ready_i(arr_mwr_ready),
    .dwr_valid_o(u_dwr_valid), .data_o(u_data), .dwr_ready_i(arr_dwr_ready)
  );

  poison_port_mux #(.SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .LINE_W(LINE_W)) u_mux (
    .clk, .rst, .busy_i(busy),
    .u_mrd_valid, .u_set, .u_mwr_valid, .u_way, .u_tag, .u_dwr_valid, .u_data,
    .pl_mrd_valid, .pl_mrd_set, .pl_mrd_ready,
    .pl_mwr_valid, .pl_mwr_set, .pl_mwr_way, .pl_mwr_tag, .pl_mwr_ready,
    .pl_drd_valid, .pl_drd_set, .pl_drd_ready,
    .pl_dwr_valid, .pl_dwr_set, .pl_dwr_way, .pl_dwr_data, .pl_dwr_ready,
    .arr_mrd_valid, .arr_mrd_set, .arr_mrd_ready,
    .arr_mwr_valid, .arr_mwr_set, .arr_mwr_way, .arr_mwr_tag, .arr_mwr_poison, .arr_mwr_ready,
    .arr_drd_valid, .arr_drd_set, .arr_drd_ready,
    .arr_dwr_valid, .arr_dwr_set, .arr_dwr_way, .arr_dwr_data, .arr_dwr_poison, .arr_dwr_ready
  );
endmodule

// File: tb/tb_icache_poison_ctl.sv
`timescale 1ns/1ps
module tb_icache_poison_ctl;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h3802_2080;
  localparam int PA_W = 36, SET_LO = 6, SET_W = 6, TAG_LO = 12, WAYS = 4, LINE_W = 64;
  localparam int TAG_W = PA_W - TAG_LO;
  localparam logic [AW-1:0] A_CTRL = BASE, A_ADDR = BASE + 32'h8;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_re = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic ecc_check_en;
  logic pl_mrd_valid = 0, pl_mwr_valid = 0, pl_drd_valid = 0, pl_dwr_valid = 0;
  logic [SET_W-1:0] pl_mrd_set = '0, pl_mwr_set = '0, pl_drd_set = '0, pl_dwr_set = '0;
  logic [WAYS-1:0] pl_mwr_way = '0, pl_dwr_way = '0;
  logic [TAG_W-1:0] pl_mwr_tag = '0;
  logic [LINE_W-1:0] pl_dwr_data = '0;
  logic pl_mrd_ready, pl_mwr_ready, pl_drd_ready, pl_dwr_ready;
  logic arr_mrd_valid, arr_mwr_valid, arr_drd_valid, arr_dwr_valid;
  logic [SET_W-1:0] arr_mrd_set, arr_mwr_set, arr_drd_set, arr_dwr_set;
  logic [WAYS-1:0] arr_mwr_way, arr_dwr_way;
  logic [TAG_W-1:0] arr_mwr_tag;
  logic [LINE_W-1:0] arr_dwr_data;
  logic arr_mwr_poison, arr_dwr_poison;
  logic arr_mrd_ready = 0, arr_mwr_ready = 0, arr_drd_ready = 0, arr_dwr_ready = 0;
  logic arr_mrsp_valid = 0;
  logic [WAYS*TAG_W-1:0] arr_mrsp_tags = '0;
  logic [WAYS-1:0] arr_mrsp_vbits = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  icache_poison_ctl dut (.*);

  function automatic logic [63:0] ctrl_val(input logic en, input logic [1:0] tg,
                                           input logic [2:0] st, input logic [2:0] rs);
    return {54'd0, rs, st, tg, 1'b0, en};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    cyc(); reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc(); reg_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
    cyc(); reg_re = 1; reg_addr = a;
    cyc(); reg_re = 0; #1 d = reg_rdata;
  endtask

  task automatic rand_pl();
    pl_mrd_valid = 1'($urandom); pl_mrd_set = SET_W'($urandom);
    pl_mwr_valid = 1'($urandom); pl_mwr_set = SET_W'($urandom);
    pl_mwr_way = WAYS'($urandom); pl_mwr_tag = TAG_W'($urandom);
    pl_drd_valid = 1'($urandom); pl_drd_set = SET_W'($urandom);
    pl_dwr_valid = 1'($urandom); pl_dwr_set = SET_W'($urandom);
    pl_dwr_way = WAYS'($urandom); pl_dwr_data = {$urandom, $urandom};
    arr_mwr_ready = 1'($urandom); arr_drd_ready = 1'($urandom);
    arr_dwr_ready = 1'($urandom); arr_mrd_ready = 1'($urandom);
  endtask

  task automatic chk_idle_pass(input string req);
    chk({req, " mrd"}, {arr_mrd_valid, arr_mrd_set, pl_mrd_ready},
        {pl_mrd_valid, pl_mrd_set, arr_mrd_ready});
    chk({req, " mwr"}, {arr_mwr_valid, arr_mwr_set, arr_mwr_way, arr_mwr_tag, arr_mwr_poison, pl_mwr_ready},
        {pl_mwr_valid, pl_mwr_set, pl_mwr_way, pl_mwr_tag, 1'b0, arr_mwr_ready});
    chk({req, " drd"}, {arr_drd_valid, arr_drd_set, pl_drd_ready},
        {pl_drd_valid, pl_drd_set, arr_drd_ready});
    chk({req, " dwr"}, {arr_dwr_valid, arr_dwr_set, arr_dwr_way, arr_dwr_poison, pl_dwr_ready},
        {pl_dwr_valid, pl_dwr_set, pl_dwr_way, 1'b0, arr_dwr_ready});
    chk({req, " dwr data"}, arr_dwr_data, pl_dwr_data);
  endtask

  // mode 0: hit, 1: miss, 2: hit with register writes while busy
  task automatic run_inject(input logic [PA_W-1:0] pa, input logic [1:0] tg, input int mode);
    logic [TAG_W-1:0] t = pa[PA_W-1:TAG_LO];
    logic [SET_W-1:0] s = pa[SET_LO +: SET_W];
    int hw = $urandom % WAYS;
    logic [63:0] d;
    for (int i = 0; i < WAYS; i++) begin
      logic [TAG_W-1:0] tv = TAG_W'($urandom);
      logic vb = 1'($urandom);
      if (tv == t) tv = tv ^ 1;
      if (i < hw && $urandom % 2 == 1) begin tv = t; vb = 0; end
      if (i == hw) begin tv = t; vb = (mode != 1); end
      if (i > hw && mode != 1 && $urandom % 2 == 1) begin tv = t; vb = 1; end
      arr_mrsp_tags[i*TAG_W +: TAG_W] = tv;
      arr_mrsp_vbits[i] = vb;
    end
    arr_mrd_ready = 0; arr_mwr_ready = 0; arr_dwr_ready = 0; arr_drd_ready = 1;
    wr(A_ADDR, 64'(pa));
    wr(A_CTRL, ctrl_val(1'b1, tg, 3'd0, 3'd0) | 64'h2);
    #1;
    chk("R5 read request raised", {arr_mrd_valid, arr_mrd_set}, {1'b1, s});
    chk("R9 data read withheld while busy", {arr_drd_valid, pl_drd_ready}, 2'b00);
    repeat ($urandom % 3) begin
      cyc(); #1 chk("R5 read request held", {arr_mrd_valid, arr_mrd_set}, {1'b1, s});
    end
    arr_mrd_ready = 1; #1;
    chk("R9 pipeline ready blocked", pl_mrd_ready, 1'b0);
    cyc(); arr_mrd_ready = 0; #1;
    chk("R5 read request dropped after handshake", arr_mrd_valid, 1'b0);
    rd(A_CTRL, d);
    chk("R5 status working", d, ctrl_val(1'b1, tg, 3'd1, 3'd0));
    if (mode == 2) begin
      wr(A_ADDR, ~64'(pa));
      wr(A_CTRL, ctrl_val(1'b0, ~tg, 3'd0, 3'd0));
    end
    arr_mrsp_valid = 1;
    cyc(); arr_mrsp_valid = 0; #1;
    if (mode == 1) begin
      chk_idle_pass("R6 idle after miss");
      rd(A_CTRL, d);
      chk("R6 miss status/reason", d, ctrl_val(1'b1, tg, 3'd7, 3'd2));
    end else if (tg == 2'd0) begin
      chk("R7 tag write payload", {arr_mwr_valid, arr_mwr_set, arr_mwr_way, arr_mwr_tag, arr_mwr_poison, arr_dwr_valid},
          {1'b1, s, WAYS'(1) << hw, t, 1'b1, 1'b0});
      repeat ($urandom % 3) begin
        cyc(); #1 chk("R7 tag write held", arr_mwr_valid, 1'b1);
      end
      arr_mwr_ready = 1; cyc(); arr_mwr_ready = 0;
      rd(A_CTRL, d);
      chk("R7 status injected", d, ctrl_val(1'b1, tg, 3'd2, 3'd0));
    end else begin
      chk("R8 data write payload", {arr_dwr_valid, arr_dwr_set, arr_dwr_way, arr_dwr_poison, arr_mwr_valid},
          {1'b1, s, WAYS'(1) << hw, 1'b1, 1'b0});
      repeat ($urandom % 3) begin
        cyc(); #1 chk("R8 data write held", arr_dwr_valid, 1'b1);
      end
      arr_dwr_ready = 1; cyc(); arr_dwr_ready = 0;
      rd(A_CTRL, d);
      chk("R8 status injected", d, ctrl_val(1'b1, tg, 3'd2, 3'd0));
    end
    if (mode == 2) begin
      rd(A_ADDR, d);
      chk("R10 address write dropped while busy", d, 64'(pa));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #2 rst = 0;
    // R1 reset state
    rd(A_CTRL, d); chk("R1 control after reset", d, 64'd0);
    rd(A_ADDR, d); chk("R1 address after reset", d, 64'd0);
    chk("R1 check enable after reset", ecc_check_en, 1'b0);
    rand_pl(); #1 chk_idle_pass("R1 ports owned by pipeline");

    // R2 register layout
    wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFD);
    rd(A_CTRL, d); chk("R2 control read-only fields", d, ctrl_val(1'b1, 2'd3, 3'd0, 3'd0));
    chk("R2 check enable output", ecc_check_en, 1'b1);
    wr(A_ADDR, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_ADDR, d); chk("R2 address width", d, (64'd1 << PA_W) - 1);
    rd(BASE + 32'h10, d); chk("R2 unused word", d, 64'd0);
    wr(BASE + 32'h80, 64'd0);
    rd(A_CTRL, d); chk("R2 write outside window ignored", d, ctrl_val(1'b1, 2'd3, 3'd0, 3'd0));
    wr(A_CTRL, 64'd0);
    chk("R2 check enable cleared", ecc_check_en, 1'b0);

    // R3 enable off has priority
    wr(A_CTRL, ctrl_val(1'b0, 2'd3, 3'd0, 3'd0) | 64'h2);
    #1 chk("R3 no read request", arr_mrd_valid, pl_mrd_valid);
    rd(A_CTRL, d); chk("R3 disabled reason", d, ctrl_val(1'b0, 2'd3, 3'd7, 3'd0));
    // R4 reserved targets
    wr(A_CTRL, ctrl_val(1'b1, 2'd1, 3'd0, 3'd0) | 64'h2);
    #1 chk("R4 no read request", arr_mrd_valid, pl_mrd_valid);
    rd(A_CTRL, d); chk("R4 target 1 reason", d, ctrl_val(1'b1, 2'd1, 3'd7, 3'd1));
    wr(A_CTRL, ctrl_val(1'b1, 2'd3, 3'd0, 3'd0) | 64'h2);
    rd(A_CTRL, d); chk("R4 target 3 reason", d, ctrl_val(1'b1, 2'd3, 3'd7, 3'd1));

    // directed sequences
    run_inject(36'h0_1234_5678, 2'd0, 0);
    run_inject(36'hF_FFFF_FFC0, 2'd2, 0);
    run_inject(36'h0_0000_0040, 2'd0, 1);
    run_inject(36'h3_0303_0303, 2'd2, 2);

    // R9 idle passthrough with random pipeline traffic
    for (int i = 0; i < 20; i++) begin
      cyc(); rand_pl(); #1 chk_idle_pass("R9 idle passthrough");
    end

    // random sequences
    for (int i = 0; i < 40; i++) begin
      run_inject({4'($urandom), $urandom}, ($urandom % 2 == 1) ? 2'd2 : 2'd0,
                 ($urandom % 4 == 0) ? 1 : 0);
      cyc(); rand_pl(); #1 chk_idle_pass("R9 idle after sequence");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule